// File: doc/BRIEF.md
# Retention Register with Shadow Copy

This block holds a parameterized-width data word inside a domain whose supply can be switched off. Next to it sits a shadow copy that is kept on an always-powered rail. A save command takes a snapshot of the live word into the shadow. A restore command writes the snapshot back into the live word. When the domain loses power, the live word is gone, but the shadow keeps its contents. All controls are sampled on the rising clock edge. The save and restore commands act on the transition into their configured active level, and that level can be set high or low per control by parameter.

New data enters over a valid/ready interface. A word is taken on a rising edge when valid and ready are both high. Ready is low in three cases: while the domain is unpowered, while reset is applied, and in a cycle in which a restore command fires. A producer holds its word and valid until ready returns. The output word is a plain level with no back-pressure. In simulation, an unknown level on the save control fills the shadow with the default word. An unknown level on the restore control sets the live word to the default word.

Top module: `ret_shadow_reg`

## Requirements
- R1: With reset high at a rising edge and power on, the output becomes the default word and err is low. Reset always clears the shadow to the default word and forgets any earlier save, whether the domain is on or off. After reset is released with power on, in_ready is high.
- R2: With power on and reset low, a word offered while in_valid and in_ready are both high appears on q after that edge. in_ready is low while power is off.
- R3: A save edge with power on and no restore edge in the same cycle copies the value q held before the edge into the shadow. A later restore returns that value.
- R4: Only the transition into the active save level saves. Holding save active over later cycles leaves the shadow unchanged while the live word is reloaded.
- R5: A restore edge with power on, a save since reset and no save edge in the same cycle loads the shadow into the live word. In that cycle in_ready is low, so an offered word is not taken.
- R6: Save and restore edges in the same cycle raise err for exactly one cycle. The shadow and the live word both stay unchanged.
- R7: A restore edge with no save since the last reset raises err for one cycle and loads the default word.
- R8: While power is off, q reads the lost pattern. In that state clock, reset, offered data, save and restore have no effect on the live word. After power returns, q keeps the lost pattern until a load, restore or reset.
- R9: The shadow keeps its contents through a power-off period. A restore after power returns gives back the saved word.
- R10: With the save and restore senses set active-low, a high-to-low transition of each control is the command edge. The bench runs in this configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pwr_on | input | 1 | High while the domain supply is on |
| in_valid | input | 1 | Offered data word is valid |
| in_ready | output | 1 | Block can take a word this cycle |
| d | input | W | Offered data word |
| save_ctl | input | 1 | Save command, sense set by SAVE_ACT_HIGH |
| rest_ctl | input | 1 | Restore command, sense set by REST_ACT_HIGH |
| q | output | W | Live word, or the lost pattern while unpowered |
| err | output | 1 | One-cycle pulse on a save/restore clash or a restore with no save |

## Verification
The properties assume that reset is applied with power on at start-up. They also assume that save and restore stay at their inactive level during reset, so the first command edge comes after release. They take pwr_on as a clean level that changes only between clock edges, with no X on any control. The stimulus changes inputs only just after falling edges, opens each power-off window with the controls idle, and issues clashing commands only with power on, so every command edge falls in a cycle with a defined supply state.

// File: rtl/ret_pkg.sv
package ret_pkg;

  typedef enum logic [2:0] {
    LV_HOLD,
    LV_INIT,
    LV_LOST,
    LV_LOAD,
    LV_RESTORE
  } live_op_t;

  typedef enum logic [1:0] {
    SH_HOLD,
    SH_CLEAR,
    SH_FILL_DEF,
    SH_CAPTURE
  } shadow_op_t;

endpackage

// File: rtl/ret_sense_edge.sv
module ret_sense_edge #(
  parameter bit ACT_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic ctl,
  output logic fire,
  output logic unk
);
  logic act;
  logic prev_q;

  always_comb begin
    unk  = $isunknown(ctl);
    act  = unk ? 1'b0 : (ctl == ACT_HIGH);
    fire = act && !prev_q;
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= act;
  end
endmodule

// File: rtl/ret_shadow_store.sv
module ret_shadow_store
  import ret_pkg::*;
#(
  parameter int         W       = 8,
  parameter logic [W-1:0] DEF_VAL = '0
) (
  input  logic         clk,
  input  shadow_op_t   op,
  input  logic [W-1:0] cap,
  output logic [W-1:0] shadow,
  output logic         saved
);
  always_ff @(posedge clk) begin
    case (op)
      SH_CLEAR:    begin shadow <= DEF_VAL; saved <= 1'b0; end
      SH_FILL_DEF: begin shadow <= DEF_VAL; saved <= 1'b1; end
      SH_CAPTURE:  begin shadow <= cap;     saved <= 1'b1; end
      default:     begin shadow <= shadow;  saved <= saved; end
    endcase
  end
endmodule

// File: rtl/ret_live_reg.sv
module ret_live_reg
  import ret_pkg::*;
#(
  parameter int           W        = 8,
  parameter logic [W-1:0] DEF_VAL  = '0,
  parameter logic [W-1:0] LOST_VAL = '1
) (
  input  logic         clk,
  input  live_op_t     op,
  input  logic [W-1:0] din,
  input  logic [W-1:0] shadow,
  output logic [W-1:0] live
);
  always_ff @(posedge clk) begin
    case (op)
      LV_INIT:    live <= DEF_VAL;
      LV_LOST:    live <= LOST_VAL;
      LV_LOAD:    live <= din;
      LV_RESTORE: live <= shadow;
      default:    live <= live;
    endcase
  end
endmodule

// File: rtl/ret_shadow_reg.sv
module ret_shadow_reg
  import ret_pkg::*;
#(
  parameter int           W             = 8,
  parameter bit           SAVE_ACT_HIGH = 1'b1,
  parameter bit           REST_ACT_HIGH = 1'b1,
  parameter logic [W-1:0] DEF_VAL       = '0,
  parameter logic [W-1:0] LOST_VAL      = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pwr_on,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  input  logic         save_ctl,
  input  logic         rest_ctl,
  output logic [W-1:0] q,
  output logic         err
);
  logic         save_fire, save_unk;
  logic         rest_fire, rest_unk;
  logic [W-1:0] live_q, shadow_q;
  logic         saved_q;
  logic         err_q;
  live_op_t     lop;
  shadow_op_t   sop;
  logic         clash, rest_go, save_go;

  ret_sense_edge #(.ACT_HIGH(SAVE_ACT_HIGH)) u_save_edge (
    .clk(clk), .rst(rst), .ctl(save_ctl), .fire(save_fire), .unk(save_unk)
  );

  ret_sense_edge #(.ACT_HIGH(REST_ACT_HIGH)) u_rest_edge (
    .clk(clk), .rst(rst), .ctl(rest_ctl), .fire(rest_fire), .unk(rest_unk)
  );

  always_comb begin
    clash    = pwr_on && save_fire && rest_fire;
    rest_go  = pwr_on && rest_fire && !save_fire;
    save_go  = pwr_on && save_fire && !rest_fire;
    in_ready = pwr_on && !rst && !rest_fire && !rest_unk;

    if (!pwr_on)                  lop = LV_LOST;
    else if (rst || rest_unk)     lop = LV_INIT;
    else if (rest_go)             lop = saved_q ? LV_RESTORE : LV_INIT;
    else if (in_valid && in_ready) lop = LV_LOAD;
    else                          lop = LV_HOLD;

    if (rst)           sop = SH_CLEAR;
    else if (save_unk) sop = SH_FILL_DEF;
    else if (save_go)  sop = SH_CAPTURE;
    else               sop = SH_HOLD;
  end

  ret_live_reg #(.W(W), .DEF_VAL(DEF_VAL), .LOST_VAL(LOST_VAL)) u_live (
    .clk(clk), .op(lop), .din(d), .shadow(shadow_q), .live(live_q)
  );

  ret_shadow_store #(.W(W), .DEF_VAL(DEF_VAL)) u_shadow (
    .clk(clk), .op(sop), .cap(live_q), .shadow(shadow_q), .saved(saved_q)
  );

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= clash || (rest_go && !saved_q);
  end

  assign q   = pwr_on ? live_q : LOST_VAL;
  assign err = err_q;
endmodule

// File: rtl/ret_shadow_reg_chk.sv
module ret_shadow_reg_chk #(
  parameter int           W        = 8,
  parameter logic [W-1:0] LOST_VAL = '1
) (
  input logic         clk,
  input logic         rst,
  input logic         pwr_on,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] d,
  input logic [W-1:0] q,
  input logic         err,
  input logic         save_fire,
  input logic         rest_fire,
  input logic [W-1:0] shadow_q,
  input logic         saved_q
);
  // R2
  a_r2_load_lands: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> (!pwr_on || q == $past(d)));

  // R3
  a_r3_save_captures: assert property (@(posedge clk) disable iff (rst)
    pwr_on && save_fire && !rest_fire |=> shadow_q == $past(q));

  // R5
  a_r5_restore_returns: assert property (@(posedge clk) disable iff (rst)
    pwr_on && rest_fire && !save_fire && saved_q |=> (!pwr_on || q == $past(shadow_q)));

  // R6
  a_r6_clash_flags: assert property (@(posedge clk) disable iff (rst)
    pwr_on && save_fire && rest_fire |=> err && $stable(shadow_q));

  // R7
  a_r7_unsaved_restore: assert property (@(posedge clk) disable iff (rst)
    pwr_on && rest_fire && !saved_q |=> err);

  // R8
  a_r8_lost_on_wake: assert property (@(posedge clk) disable iff (rst)
    pwr_on && !$past(pwr_on) |-> q == LOST_VAL);
endmodule

bind ret_shadow_reg ret_shadow_reg_chk #(.W(W), .LOST_VAL(LOST_VAL)) u_chk (
  .clk(clk), .rst(rst), .pwr_on(pwr_on), .in_valid(in_valid), .in_ready(in_ready),
  .d(d), .q(q), .err(err), .save_fire(save_fire), .rest_fire(rest_fire),
  .shadow_q(shadow_q), .saved_q(saved_q)
);

// File: tb/test_ret_shadow_reg.sv
`timescale 1ns/1ps
module test_ret_shadow_reg;
  localparam int           W    = 4;
  localparam logic [W-1:0] DEF  = 4'h5;
  localparam logic [W-1:0] LOST = 4'hF;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pwr_on = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] d = '0;
  logic         save_n = 1'b1;
  logic         rest_n = 1'b1;
  logic         in_ready;
  logic [W-1:0] q;
  logic         err;
  int           total = 0;
  int           bad = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  // R10: both command senses configured active-low
  ret_shadow_reg #(
    .W(W), .SAVE_ACT_HIGH(1'b0), .REST_ACT_HIGH(1'b0), .DEF_VAL(DEF), .LOST_VAL(LOST)
  ) i_ret_shadow_reg (
    .clk(clk), .rst(rst), .pwr_on(pwr_on), .in_valid(in_valid), .in_ready(in_ready),
    .d(d), .save_ctl(save_n), .rest_ctl(rest_n), .q(q), .err(err)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic load(input logic [W-1:0] v);
    in_valid = 1'b1; d = v; cyc(); in_valid = 1'b0;
  endtask

  task automatic save();
    save_n = 1'b0; cyc(); save_n = 1'b1; cyc();
  endtask

  task automatic restore();
    rest_n = 1'b0; cyc(); rest_n = 1'b1;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    chk("R1 reset q", q, DEF);
    chk("R1 reset err", {3'b0, err}, 4'h0);
    rst = 1'b0; #1;
    chk("R1 ready after release", {3'b0, in_ready}, 4'h1);
    cyc();

    // R9/R10 sweep over every word: save, overwrite, power cycle, restore
    for (int v = 0; v < 16; v++) begin
      logic [W-1:0] w, nw;
      w = v[W-1:0]; nw = ~w;
      load(w);
      chk("R2 load", q, w);
      save();
      load(nw);
      chk("R2 overwrite", q, nw);
      pwr_on = 1'b0; #1;
      chk("R8 off pattern", q, LOST);
      chk("R2 ready off", {3'b0, in_ready}, 4'h0);
      cyc();
      in_valid = 1'b1; d = w ^ 4'h3; save_n = 1'b0; cyc();
      rest_n = 1'b0; cyc();
      chk("R8 off ignores inputs", q, LOST);
      in_valid = 1'b0; save_n = 1'b1; rest_n = 1'b1; cyc();
      pwr_on = 1'b1; #1;
      chk("R8 wake lost", q, LOST);
      cyc();
      chk("R8 wake hold", q, LOST);
      restore();
      chk("R9 R10 restored", q, w);
      chk("R3 no err", {3'b0, err}, 4'h0);
      cyc();
    end

    // R4: held save level does not save again
    load(4'h3);
    save_n = 1'b0; cyc(); cyc();
    load(4'h9);
    cyc();
    save_n = 1'b1; cyc();
    chk("R4 live reloaded", q, 4'h9);
    restore();
    chk("R4 single save", q, 4'h3);
    cyc();

    // R5: restore beats an offered word
    load(4'h4); save(); load(4'h8);
    rest_n = 1'b0; in_valid = 1'b1; d = 4'h1; #1;
    chk("R5 ready low on restore", {3'b0, in_ready}, 4'h0);
    cyc();
    in_valid = 1'b0; rest_n = 1'b1;
    chk("R5 restore wins", q, 4'h4);
    cyc();

    // R6: clash
    load(4'h6); save(); load(4'h2);
    save_n = 1'b0; rest_n = 1'b0; cyc();
    chk("R6 err pulse", {3'b0, err}, 4'h1);
    chk("R6 live kept", q, 4'h2);
    save_n = 1'b1; rest_n = 1'b1; cyc();
    chk("R6 err one cycle", {3'b0, err}, 4'h0);
    restore();
    chk("R6 shadow kept", q, 4'h6);
    cyc();

    // R7: restore without save
    rst = 1'b1; cyc(); rst = 1'b0;
    load(4'h7);
    restore();
    chk("R7 err", {3'b0, err}, 4'h1);
    chk("R7 default", q, DEF);
    cyc();
    chk("R7 err clears", {3'b0, err}, 4'h0);

    // R8 / R1: reset while unpowered
    load(4'hC); save();
    pwr_on = 1'b0; cyc();
    rst = 1'b1; cyc();
    rst = 1'b0; pwr_on = 1'b1; #1;
    chk("R8 reset off no effect", q, LOST);
    cyc();
    restore();
    chk("R1 shadow cleared err", {3'b0, err}, 4'h1);
    chk("R1 shadow cleared q", q, DEF);
    cyc();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule